// File: doc/BRIEF.md
# Kernel Launch Register Front End

This block is the host-facing register window of a compute dispatcher. A host builds a launch descriptor by writing bytes into the window, starting at address 8. A write of any width to address 0 then rings the doorbell. On that doorbell the block freezes the current descriptor contents into a free kernel slot and gives the kernel the next sequential ID. It also works out the workgroup grid: the number of workgroups in each of three dimensions and their product.

The kernel slots form an in-order queue of pending launches. A dispatch scheduler sits downstream. It sees the oldest pending record on the `kq_*` outputs and removes it with `kq_pop`. A 64-bit read at address 0 returns the dispatch-active flag. The flag rises on a launch and falls when the last pending kernel leaves the queue.

Accesses take one cycle. Every accepted request gets a response on the next cycle. The response carries read data and an error flag for illegal accesses.

Top module: `kl_front`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_err` and `kq_valid` are 0, all 32 descriptor bytes read back as 0, and a 64-bit read at address 0 returns 0.
- R2: A read at address 0 with size code 3 (8 bytes) returns the dispatch-active flag in bit 0 with the upper 63 bits zero. A read at address 0 with any other size sets `rsp_err` and returns 0.
- R3: An access is illegal, sets `rsp_err`, returns 0 and changes no state in these cases: a read or write at address 1 to 7; an address of 4096 or more; a descriptor access (address 8 or more) whose last byte lies beyond address 39. Writes to address 0 are exempt from this rule.
- R4: Descriptor byte i sits at address 8+i, for i from 0 to 31. `req_size` codes 0, 1, 2 and 3 move 1, 2, 4 and 8 bytes. Data is little-endian: `req_wdata[7:0]` and `rsp_rdata[7:0]` are the byte at the lowest address. Unused upper read bytes are 0. Any alignment is allowed.
- R5: A write to address 0 is a launch, whatever its size or data. Accepted launches get IDs 0, 1, 2 and so on, in order, and the launch sets the dispatch-active flag.
- R6: The descriptor layout uses little-endian 32-bit words. Grid sizes X, Y and Z sit at bytes 0, 4 and 8. Workgroup sizes X, Y and Z sit at bytes 12, 16 and 20. A 64-bit notify address sits at bytes 24 to 31. Each per-dimension count is ceil(grid/workgroup). The 96-bit total is the product of the three counts. The launched record carries all of these values as they stood at the launch.
- R7: A launch with any workgroup size equal to 0 sets `rsp_err`. It enqueues nothing and does not consume an ID.
- R8: When all NSLOTS slots hold pending kernels, `req_ready` is low for a write to address 0 until a pop frees a slot. Other accesses are not stalled.
- R9: Records leave in launch order. `kq_valid` is high while any kernel is pending. The dispatch-active flag clears when the last pending kernel is popped.
- R10: Each request accepted with `req_valid` and `req_ready` high produces `rsp_valid` for exactly one cycle, on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data, little-endian |
| req_ready | output | 1 | Low while a launch write must wait for a free slot |
| rsp_valid | output | 1 | Response for the request accepted on the previous cycle |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Illegal access or rejected launch |
| kq_valid | output | 1 | A pending kernel record is presented |
| kq_pop | input | 1 | Scheduler takes the presented record |
| kq_id | output | ID_W | Kernel ID |
| kq_wg_x | output | 32 | Workgroup count, X |
| kq_wg_y | output | 32 | Workgroup count, Y |
| kq_wg_z | output | 32 | Workgroup count, Z |
| kq_wg_total | output | 96 | Total workgroup count |
| kq_notify | output | 64 | Notify address from the descriptor |

## Verification
The assertions assume the following about the inputs: the host holds its request steady while `req_ready` is low, `req_size` is always a defined code, and `kq_pop` is raised only while `kq_valid` is high. The bench keeps to these rules in three ways. It drives each request at the falling edge and holds it until acceptance. It issues pops only after it has seen `kq_valid`. When it sees a stall, it withdraws the launch rather than changing it. The workgroup arithmetic is swept over a dense grid of small X sizes against bench-computed ceilings. A few extreme 32-bit operands then exercise the full 96-bit product.

// File: rtl/kl_front.sv
module kl_front #(
  parameter int ADDR_W = 16,
  parameter int WIN    = 4096,
  parameter int NSLOTS = 4,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              kq_valid,
  input  logic              kq_pop,
  output logic [ID_W-1:0]   kq_id,
  output logic [31:0]       kq_wg_x,
  output logic [31:0]       kq_wg_y,
  output logic [31:0]       kq_wg_z,
  output logic [95:0]       kq_wg_total,
  output logic [63:0]       kq_notify
);
  localparam int DESC_B = 32;
  localparam int PTR_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam int CNT_W  = $clog2(NSLOTS + 1);

  function automatic logic [31:0] cdiv(input logic [31:0] g, input logic [31:0] w);
    if (w == 32'd0) return 32'd0;
    return g / w + (((g % w) != 32'd0) ? 32'd1 : 32'd0);
  endfunction

  logic [DESC_B*8-1:0] desc_q;
  logic [ID_W-1:0]     next_id;
  logic [CNT_W-1:0]    count;
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic                active;

  logic [ID_W-1:0] r_id  [NSLOTS];
  logic [31:0]     r_cx  [NSLOTS];
  logic [31:0]     r_cy  [NSLOTS];
  logic [31:0]     r_cz  [NSLOTS];
  logic [95:0]     r_tot [NSLOTS];
  logic [63:0]     r_nt  [NSLOTS];

  logic [3:0]      nbytes;
  logic [ADDR_W:0] end_addr;
  logic [4:0]      bidx;
  logic            is_launch, desc_ok, rd0_ok, wg_zero, full, accept, push, pop, err;
  logic [31:0]     cx, cy, cz;
  logic [63:0]     rd_desc;

  assign nbytes    = 4'd1 << req_size;
  assign end_addr  = {1'b0, req_addr} + (ADDR_W+1)'(nbytes);
  assign bidx      = 5'(req_addr - ADDR_W'(8));
  assign is_launch = req_write && (req_addr == '0);
  assign desc_ok   = (req_addr >= ADDR_W'(8)) && (req_addr < ADDR_W'(WIN))
                     && (end_addr <= (ADDR_W+1)'(DESC_B + 8));
  assign rd0_ok    = !req_write && (req_addr == '0) && (req_size == 2'd3);
  assign wg_zero   = (desc_q[127:96] == 32'd0) || (desc_q[159:128] == 32'd0)
                     || (desc_q[191:160] == 32'd0);
  assign full      = (count == CNT_W'(NSLOTS));
  assign req_ready = !(req_valid && is_launch && full);
  assign accept    = req_valid && req_ready;
  assign push      = accept && is_launch && !wg_zero;
  assign kq_valid  = (count != '0);
  assign pop       = kq_pop && kq_valid;
  assign err       = is_launch ? wg_zero : (req_write ? !desc_ok : !(rd0_ok || desc_ok));

  assign cx = cdiv(desc_q[31:0],  desc_q[127:96]);
  assign cy = cdiv(desc_q[63:32], desc_q[159:128]);
  assign cz = cdiv(desc_q[95:64], desc_q[191:160]);

  always_comb
    for (int k = 0; k < 8; k++)
      rd_desc[k*8 +: 8] = (4'(k) < nbytes) ? desc_q[{bidx + 5'(k), 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_q    <= '0;
      next_id   <= '0;
      count     <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      active    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept && err;
      rsp_rdata <= (!accept || err || req_write) ? 64'd0 :
                   (rd0_ok ? {63'd0, active} : rd_desc);
      if (accept && req_write && !is_launch && desc_ok)
        for (int k = 0; k < 8; k++)
          if (4'(k) < nbytes) desc_q[{bidx + 5'(k), 3'b000} +: 8] <= req_wdata[k*8 +: 8];
      if (push) begin
        next_id <= next_id + 1'b1;
        wr_ptr  <= (wr_ptr == PTR_W'(NSLOTS-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == PTR_W'(NSLOTS-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (push) active <= 1'b1;
      else if (pop && count == CNT_W'(1)) active <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (push) begin
      r_id[wr_ptr]  <= next_id;
      r_cx[wr_ptr]  <= cx;
      r_cy[wr_ptr]  <= cy;
      r_cz[wr_ptr]  <= cz;
      r_tot[wr_ptr] <= 96'(cx) * 96'(cy) * 96'(cz);
      r_nt[wr_ptr]  <= desc_q[255:192];
    end

  assign kq_id       = r_id[rd_ptr];
  assign kq_wg_x     = r_cx[rd_ptr];
  assign kq_wg_y     = r_cy[rd_ptr];
  assign kq_wg_z     = r_cz[rd_ptr];
  assign kq_wg_total = r_tot[rd_ptr];
  assign kq_notify   = r_nt[rd_ptr];

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == '0 && count == CNT_W'(NSLOTS)) |-> !req_ready); // R8
  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> next_id == $past(next_id) + 1'b1); // R5
  AST_ACTIVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> active); // R5
  AST_ZERO_WG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_launch && wg_zero) |=> (rsp_err && next_id == $past(next_id))); // R7
  AST_PENDING_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    kq_valid |-> active); // R9
endmodule

// File: tb/kl_front_test.sv
module kl_front_test;
  localparam int CLK_P = 10;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, kq_pop = 0;
  logic [15:0] req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, kq_valid;
  logic [63:0] rsp_rdata, kq_notify;
  logic [7:0]  kq_id;
  logic [31:0] kq_wg_x, kq_wg_y, kq_wg_z;
  logic [95:0] kq_wg_total;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [63:0] g_d;
  logic g_e, g_v;
  int exp_id = 0;

  always #(CLK_P/2) clk = ~clk;

  kl_front uut (.clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
    .req_ready, .rsp_valid, .rsp_rdata, .rsp_err, .kq_valid, .kq_pop, .kq_id,
    .kq_wg_x, .kq_wg_y, .kq_wg_z, .kq_wg_total, .kq_notify);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic acc(input bit w, input logic [15:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    g_v = rsp_valid; g_d = rsp_rdata; g_e = rsp_err;
  endtask

  task automatic pop_chk(input int id, input logic [31:0] x, y, z, input logic [95:0] t, input string tag);
    @(negedge clk);
    chk(kq_valid, {tag, " R9 valid"}, kq_valid, 1);
    chk(kq_id == id[7:0], {tag, " R5 id"}, kq_id, id);
    chk(kq_wg_x == x && kq_wg_y == y && kq_wg_z == z, {tag, " R6 counts"},
        {kq_wg_x, kq_wg_y, kq_wg_z}, {x, y, z});
    chk(kq_wg_total == t, {tag, " R6 total"}, kq_wg_total, t);
    kq_pop = 1;
    @(posedge clk);
    @(negedge clk);
    kq_pop = 0;
  endtask

  function automatic logic [31:0] cd(input logic [31:0] g, input logic [31:0] w);
    return 32'((64'(g) + 64'(w) - 1) / 64'(w));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !rsp_err && !kq_valid, "R1 reset outputs", {rsp_valid, rsp_err, kq_valid}, 0);
    acc(0, 0, 3, 0);
    chk(g_v && !g_e && g_d == 0, "R1 active after reset", g_d, 0);
    for (int a = 8; a < 40; a += 8) begin
      acc(0, 16'(a), 3, 0);
      chk(g_d == 0 && !g_e, "R1 descriptor zero", g_d, 0);
    end
    @(negedge clk);
    chk(!rsp_valid, "R10 single-cycle response", rsp_valid, 0);

    // R4 byte lanes
    acc(1, 8, 3, 64'h0123456789ABCDEF);
    acc(0, 8, 0, 0);   chk(g_d == 64'hEF, "R4 byte 0", g_d, 64'hEF);
    acc(0, 15, 0, 0);  chk(g_d == 64'h01, "R4 byte 7", g_d, 64'h01);
    acc(0, 9, 1, 0);   chk(g_d == 64'hABCD, "R4 half unaligned", g_d, 64'hABCD);
    acc(0, 10, 2, 0);  chk(g_d == 64'h456789AB, "R4 word unaligned", g_d, 64'h456789AB);
    acc(1, 11, 0, 64'hFFFF_FF5A);
    acc(0, 8, 3, 0);   chk(g_d == 64'h0123_4567_5AAB_CDEF, "R4 single byte write", g_d, 64'h012345675AABCDEF);

    // R2 / R3 illegal accesses
    acc(0, 0, 2, 0);   chk(g_e && g_d == 0, "R2 short read at 0", {g_e, g_d}, {1'b1, 64'd0});
    for (int a = 1; a < 8; a++) begin
      acc(0, 16'(a), 0, 0); chk(g_e && g_d == 0, "R3 read offset 1-7", g_e, 1);
      acc(1, 16'(a), 0, 64'hFF); chk(g_e, "R3 write offset 1-7", g_e, 1);
    end
    acc(1, 32, 3, 64'h1111_2222_3333_4444);
    acc(0, 16'd4096, 0, 0); chk(g_e, "R3 outside window", g_e, 1);
    acc(0, 36, 3, 0);  chk(g_e && g_d == 0, "R3 read overrun", g_e, 1);
    acc(1, 36, 3, 64'hAAAA_AAAA_AAAA_AAAA); chk(g_e, "R3 write overrun", g_e, 1);
    acc(0, 36, 2, 0);  chk(!g_e && g_d == 64'h1111_2222, "R3 overrun no effect", g_d, 64'h11112222);
    acc(0, 39, 0, 0);  chk(!g_e && g_d == 64'h11, "R3 last byte legal", g_d, 64'h11);

    // R7 zero workgroup size
    acc(1, 20, 3, 64'h1_0000_0000);
    acc(1, 28, 2, 1);
    acc(1, 0, 3, 0);   chk(g_e, "R7 zero wg err", g_e, 1);
    @(negedge clk);    chk(!kq_valid, "R7 nothing queued", kq_valid, 0);
    acc(0, 0, 3, 0);   chk(g_d == 0, "R7 active unchanged", g_d, 0);

    // R6 sweep on X
    acc(1, 8, 3, {32'd1, 32'd0});
    acc(1, 16, 2, 1);
    acc(1, 24, 2, 1);
    for (int g = 0; g < 20; g++)
      for (int w = 1; w <= 6; w++) begin
        acc(1, 8, 2, 64'(g));
        acc(1, 20, 2, 64'(w));
        acc(1, 0, 0, 64'hDEAD);
        chk(!g_e, "R5 launch accepted", g_e, 0);
        pop_chk(exp_id, cd(32'(g), 32'(w)), 1, 1, 96'(cd(32'(g), 32'(w))), "sweep");
        exp_id++;
      end
    acc(0, 0, 3, 0); chk(g_d == 0, "R9 active cleared", g_d, 0);

    // R6 extreme 3-D values and notify
    acc(1, 8, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(1, 16, 2, 64'hFFFF_FFFF);
    acc(1, 20, 3, {32'd1, 32'd1});
    acc(1, 28, 2, 1);
    acc(1, 32, 3, 64'hCAFE_F00D_1234_5678);
    acc(1, 0, 1, 0);
    @(negedge clk);
    chk(kq_notify == 64'hCAFE_F00D_1234_5678, "R6 notify", kq_notify, 64'hCAFEF00D12345678);
    pop_chk(exp_id, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            96'(33'h0_FFFF_FFFF) * 96'(33'h0_FFFF_FFFF) * 96'(33'h0_FFFF_FFFF), "extreme");
    exp_id++;
    acc(1, 8, 3, {32'd100, 32'd1000});
    acc(1, 16, 2, 7);
    acc(1, 20, 3, {32'd9, 32'd64});
    acc(1, 28, 2, 3);

    // R8 full stall and R9 order
    for (int i = 0; i < NS; i++) acc(1, 0, 3, 0);
    acc(0, 0, 3, 0); chk(g_d == 1, "R2 active read", g_d, 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 0; req_size = 3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready, "R8 launch stalled when full", req_ready, 0);
    end
    req_valid = 0;
    acc(0, 12, 2, 0); chk(g_v && g_d == 100, "R8 read not stalled", g_d, 100);
    pop_chk(exp_id, 16, 12, 3, 96'(16 * 12 * 3), "order");
    acc(1, 0, 3, 0); chk(g_v && !g_e, "R8 launch after free", g_e, 0);
    for (int i = 1; i <= NS; i++) pop_chk(exp_id + i, 16, 12, 3, 96'(576), "order");
    @(negedge clk); chk(!kq_valid, "R9 queue empty", kq_valid, 0);
    acc(0, 0, 3, 0); chk(g_d == 0, "R9 active cleared after drain", g_d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule